// File: doc/BRIEF.md
# Five-Pin General Purpose I/O Port with Pullup Control

This block controls a small general purpose I/O port of five pins. Software sets it up through a byte-wide register bus with three registers: pin data, pin direction and pullup enable. For each pin the block drives four signals toward the pad ring: an output value, an output enable, an input buffer enable and a pullup enable. The pad level comes back in through a two-flop synchronizer. A read of the data register returns the stored value for output pins and the synchronized pad level for input pins.

Two other sources can claim a pin. A shared peripheral claims a pin and then drives its output value and output enable in place of the port registers. An analog function claims a pin and then turns off the digital output, the input buffer and the pullup. The pullup is never on while the pin drives, whichever source set the pin to drive.

A low-power request comes with a mode select. The deep mode clears every port register and holds all pins in their reset state, and the pins stay there after wake until software writes the port. The retention mode freezes all registers and pin controls, and on wake the pins carry on as they did before.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0x00, and pin_out, pin_oe, pin_ie and pin_pu are all 0.
- R2: The data register is at address 0x00, the direction register at 0x01 and the pullup register at 0x02, each with pins in bits 4..0. Bits 7..5 read 0 and ignore writes, and any other address reads 0x00.
- R3: With no claim on a pin, pin_oe equals that pin's direction bit (1 = output) and pin_out equals its data bit.
- R4: A data value written while a pin is an input appears on pin_out in the same cycle that pin_oe rises after a later write of the direction bit.
- R5: A data register read returns the data bit for a pin whose direction bit is 1 and the pad level for a pin whose direction bit is 0, with the pad level delayed by two clocks.
- R6: pin_pu is 1 only when the pullup bit is set and the pin is not driving. A pin set to drive by the direction register or by the peripheral has pin_pu 0.
- R7: While ana_en is 1 on a pin, its pin_oe, pin_out, pin_ie and pin_pu are all 0. This takes priority over the peripheral.
- R8: While per_en is 1 on a pin and ana_en is 0, pin_out follows per_out and pin_oe follows per_oe.
- R9: While lp_req=1 and lp_mode=1 (deep), every pin output is 0 and all registers are cleared. After lp_req falls, pin_ie stays 0 until a register write.
- R10: While lp_req=1 and lp_mode=0 (retention), bus writes are ignored and registers and pin controls keep their values, also after lp_req falls.
- R11: pin_ie is 0 after reset and after deep stop. After the first register write it is 1 on every pin that ana_en does not claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data selected by addr |
| pad_in | input | 5 | Pad level per pin (asynchronous) |
| per_en | input | 5 | Peripheral claim per pin |
| per_oe | input | 5 | Peripheral output enable per pin |
| per_out | input | 5 | Peripheral output value per pin |
| ana_en | input | 5 | Analog claim per pin |
| lp_req | input | 1 | Low-power stop active |
| lp_mode | input | 1 | 1 = deep (clear), 0 = retention |
| pin_out | output | 5 | Output value to pad |
| pin_oe | output | 5 | Output buffer enable |
| pin_ie | output | 5 | Input buffer enable |
| pin_pu | output | 5 | Pullup enable |

## Verification
The pin selection is tried with a table of register and claim patterns. These include all-output, all-input with pullups, a mixed direction pattern, peripheral claims that drive and that do not drive, analog claims over GPIO outputs, and an analog claim over a peripheral claim. Each pattern separates one priority or pullup-masking rule from its neighbours. Directed cases cover the bits that cannot be written, data written before the direction changes, the two-cycle read path from the pad, and both stop modes, with a write tried during retention.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int             N         = 5,
  parameter int             AW        = 8,
  parameter int             DW        = 8,
  parameter logic [AW-1:0]  DATA_ADDR = 8'h00,
  parameter logic [AW-1:0]  DIR_ADDR  = 8'h01,
  parameter logic [AW-1:0]  PULL_ADDR = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          deep_stop,
  input  logic          hold_stop,
  input  logic [N-1:0]  pad_sync,
  output logic [N-1:0]  data_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  pull_q,
  output logic          live_q,
  output logic [DW-1:0] rdata
);
  localparam int PADW = DW - N;

  reg_sel_e     sel;
  logic         wr_ok;
  logic [N-1:0] rd_val;

  always_comb begin
    if (addr == DATA_ADDR)      sel = SEL_DATA;
    else if (addr == DIR_ADDR)  sel = SEL_DIR;
    else if (addr == PULL_ADDR) sel = SEL_PULL;
    else                        sel = SEL_NONE;
  end

  assign wr_ok = wr_en && !deep_stop && !hold_stop;

  always_ff @(posedge clk) begin
    if (rst || deep_stop) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      live_q <= 1'b0;
    end else if (wr_ok) begin
      live_q <= 1'b1;
      case (sel)
        SEL_DATA: data_q <= wdata[N-1:0];
        SEL_DIR:  dir_q  <= wdata[N-1:0];
        SEL_PULL: pull_q <= wdata[N-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: rd_val = (dir_q & data_q) | (~dir_q & pad_sync);
      SEL_DIR:  rd_val = dir_q;
      SEL_PULL: rd_val = pull_q;
      default:  rd_val = '0;
    endcase
  end

  assign rdata = {{PADW{1'b0}}, rd_val};

  AST_DEEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    deep_stop |=> (data_q == '0 && dir_q == '0 && pull_q == '0 && !live_q)); // R9

  AST_RETAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_stop |=> ($stable(data_q) && $stable(dir_q) && $stable(pull_q) && $stable(live_q))); // R10
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] data_q,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] pull_q,
  input  logic         live_q,
  input  logic         deep_stop,
  input  logic [N-1:0] per_en,
  input  logic [N-1:0] per_oe,
  input  logic [N-1:0] per_out,
  input  logic [N-1:0] ana_en,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_ie,
  output logic [N-1:0] pin_pu
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic dig_oe;
      logic dig_out;
      logic blocked;

      assign blocked = ana_en[i] || deep_stop;
      assign dig_oe  = per_en[i] ? per_oe[i]  : dir_q[i];
      assign dig_out = per_en[i] ? per_out[i] : data_q[i];

      assign pin_oe[i]  = !blocked && dig_oe;
      assign pin_out[i] = !blocked && dig_out;
      assign pin_ie[i]  = !blocked && live_q;
      assign pin_pu[i]  = !blocked && !dig_oe && pull_q[i];

      AST_PU_OFF_DRIVE: assert property (@(posedge clk) disable iff (rst)
        pin_oe[i] |-> !pin_pu[i]); // R6

      AST_ANA_QUIET: assert property (@(posedge clk) disable iff (rst)
        ana_en[i] |-> !(pin_oe[i] || pin_out[i] || pin_ie[i] || pin_pu[i])); // R7

      AST_PER_WINS: assert property (@(posedge clk) disable iff (rst)
        (per_en[i] && !ana_en[i] && !deep_stop) |-> (pin_oe[i] == per_oe[i] && pin_out[i] == per_out[i])); // R8
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int             N         = 5,
  parameter int             AW        = 8,
  parameter int             DW        = 8,
  parameter int             SYNC_LEN  = 2,
  parameter logic [AW-1:0]  DATA_ADDR = 8'h00,
  parameter logic [AW-1:0]  DIR_ADDR  = 8'h01,
  parameter logic [AW-1:0]  PULL_ADDR = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  pad_in,
  input  logic [N-1:0]  per_en,
  input  logic [N-1:0]  per_oe,
  input  logic [N-1:0]  per_out,
  input  logic [N-1:0]  ana_en,
  input  logic          lp_req,
  input  logic          lp_mode,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_ie,
  output logic [N-1:0]  pin_pu
);
  logic         deep_stop;
  logic         hold_stop;
  logic [N-1:0] pad_sync;
  logic [N-1:0] data_q;
  logic [N-1:0] dir_q;
  logic [N-1:0] pull_q;
  logic         live_q;

  assign deep_stop = lp_req && lp_mode;
  assign hold_stop = lp_req && !lp_mode;

  gpio_sync #(.N(N), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
  );

  gpio_regs #(
    .N(N), .AW(AW), .DW(DW),
    .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .PULL_ADDR(PULL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .deep_stop(deep_stop), .hold_stop(hold_stop), .pad_sync(pad_sync),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .live_q(live_q),
    .rdata(rdata)
  );

  gpio_pin_mux #(.N(N)) u_mux (
    .clk(clk), .rst(rst),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .live_q(live_q),
    .deep_stop(deep_stop),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .ana_en(ana_en),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .pin_pu(pin_pu)
  );

  AST_DEEP_PINS: assert property (@(posedge clk) disable iff (rst)
    deep_stop |-> (pin_out == '0 && pin_oe == '0 && pin_ie == '0 && pin_pu == '0)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:N] == '0); // R2
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [4:0] pad_in, per_en, per_oe, per_out, ana_en;
  logic       lp_req, lp_mode;
  logic [4:0] pin_out, pin_oe, pin_ie, pin_pu;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .ana_en(ana_en),
    .lp_req(lp_req), .lp_mode(lp_mode),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .pin_pu(pin_pu)
  );

  // {data,dir,pull,per_en,per_oe,per_out,ana, exp_out,exp_oe,exp_pu}
  localparam logic [49:0] VEC [7] = '{
    {5'b10110,5'b11111,5'b11111,5'b00000,5'b00000,5'b00000,5'b00000, 5'b10110,5'b11111,5'b00000},
    {5'b10110,5'b00000,5'b11111,5'b00000,5'b00000,5'b00000,5'b00000, 5'b10110,5'b00000,5'b11111},
    {5'b01010,5'b00111,5'b11001,5'b00000,5'b00000,5'b00000,5'b00000, 5'b01010,5'b00111,5'b11000},
    {5'b11111,5'b00000,5'b11111,5'b00011,5'b00001,5'b00010,5'b00000, 5'b11110,5'b00001,5'b11110},
    {5'b11111,5'b11111,5'b11111,5'b00000,5'b00000,5'b00000,5'b10100, 5'b01011,5'b01011,5'b00000},
    {5'b00000,5'b00000,5'b11111,5'b10000,5'b10000,5'b10000,5'b00001, 5'b10000,5'b10000,5'b01110},
    {5'b00000,5'b00000,5'b00000,5'b00001,5'b00001,5'b00001,5'b00001, 5'b00000,5'b00000,5'b00000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; wr_en = 0; addr = 0; wdata = 0;
    pad_in = 0; per_en = 0; per_oe = 0; per_out = 0; ana_en = 0;
    lp_req = 0; lp_mode = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 data", v, 8'h00);
    rd(8'h01, v); chk("R1 dir", v, 8'h00);
    rd(8'h02, v); chk("R1 pull", v, 8'h00);
    chk("R1 pins", {pin_out, pin_oe, pin_ie, pin_pu} == 20'd0 ? 8'h00 : 8'hFF, 8'h00);
    chk("R11 ie after reset", {3'b0, pin_ie}, 8'h00);

    // R2 reserved bits and unused address
    wr(8'h01, 8'hFF);
    rd(8'h01, v); chk("R2 dir reserved", v, 8'h1F);
    wr(8'h00, 8'hFF);
    rd(8'h00, v); chk("R2 data reserved", v, 8'h1F);
    wr(8'h02, 8'hE0);
    rd(8'h02, v); chk("R2 pull reserved", v, 8'h00);
    wr(8'h03, 8'hFF);
    rd(8'h03, v); chk("R2 unused addr", v, 8'h00);
    chk("R11 ie after write", {3'b0, pin_ie}, 8'h1F);

    // Table walk: R3 R6 R7 R8
    for (int n = 0; n < 7; n++) begin
      wr(8'h00, {3'b0, VEC[n][49:45]});
      wr(8'h01, {3'b0, VEC[n][44:40]});
      wr(8'h02, {3'b0, VEC[n][39:35]});
      per_en = VEC[n][34:30]; per_oe = VEC[n][29:25];
      per_out = VEC[n][24:20]; ana_en = VEC[n][19:15];
      #1;
      chk($sformatf("R3/R8/R7 out vec%0d", n), {3'b0, pin_out}, {3'b0, VEC[n][14:10]});
      chk($sformatf("R3/R8/R7 oe vec%0d", n),  {3'b0, pin_oe},  {3'b0, VEC[n][9:5]});
      chk($sformatf("R6/R7 pu vec%0d", n),     {3'b0, pin_pu},  {3'b0, VEC[n][4:0]});
      chk($sformatf("R7/R11 ie vec%0d", n),    {3'b0, pin_ie},  {3'b0, ~VEC[n][19:15]});
    end
    per_en = 0; per_oe = 0; per_out = 0; ana_en = 0;

    // R4 data before direction
    wr(8'h01, 8'h00);
    wr(8'h00, 8'h15);
    chk("R4 still input", {3'b0, pin_oe}, 8'h00);
    wr(8'h01, 8'h1F);
    chk("R4 oe", {3'b0, pin_oe}, 8'h1F);
    chk("R4 out", {3'b0, pin_out}, 8'h15);

    // R5 readback path
    wr(8'h01, 8'h00);
    pad_in = 5'b00000;
    idle(3);
    pad_in = 5'b01010;
    @(negedge clk);
    rd(8'h00, v); chk("R5 pad after 1 clk", v, 8'h00);
    @(negedge clk);
    rd(8'h00, v); chk("R5 pad after 2 clk", v, 8'h0A);
    wr(8'h01, 8'h03);
    rd(8'h00, v); chk("R5 mixed", v, 8'h09);
    pad_in = 0;

    // R10 retention
    wr(8'h00, 8'h13);
    wr(8'h01, 8'h0F);
    wr(8'h02, 8'h10);
    lp_mode = 1'b0; lp_req = 1'b1;
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);
    idle(2);
    chk("R10 out in stop", {3'b0, pin_out}, 8'h13);
    chk("R10 pu in stop", {3'b0, pin_pu}, 8'h10);
    lp_req = 1'b0;
    @(negedge clk);
    rd(8'h01, v); chk("R10 dir kept", v, 8'h0F);
    rd(8'h02, v); chk("R10 pull kept", v, 8'h10);
    chk("R10 out after", {3'b0, pin_out}, 8'h13);
    chk("R10 oe after", {3'b0, pin_oe}, 8'h0F);

    // R9 deep stop
    lp_mode = 1'b1; lp_req = 1'b1;
    #1;
    chk("R9 pins in stop", {3'b0, pin_oe | pin_out | pin_ie | pin_pu}, 8'h00);
    idle(2);
    lp_req = 1'b0; lp_mode = 1'b0;
    @(negedge clk);
    rd(8'h00, v); chk("R9 data cleared", v, 8'h00);
    rd(8'h01, v); chk("R9 dir cleared", v, 8'h00);
    rd(8'h02, v); chk("R9 pull cleared", v, 8'h00);
    chk("R9 ie stays off", {3'b0, pin_ie}, 8'h00);
    wr(8'h02, 8'h04);
    chk("R11 ie after reconfig", {3'b0, pin_ie}, 8'h1F);
    chk("R6 pull on input", {3'b0, pin_pu}, 8'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule